// File: doc/BRIEF.md
# Toroidal Grid Row Store

This block owns the storage of a cellular-grid simulator: a two-port memory of `ROWS` words, each word `ROW_BITS` wide and holding one complete grid row. It has one read port and one write port. While a compute pass runs, the generation engine reads one row and writes one updated row in every clock cycle. Outside that traffic, the same memory serves two other clients. A loader fills rows, and a display path fetches one whole row per visible scanline.

The grid wraps top to bottom. Each pass advances the grid by `GENS_PER_PASS` generations, and the rows come back shifted by the same amount. The block therefore keeps a circular base pointer and adds it, modulo `ROWS`, to every logical row number it receives. After each pass it moves that pointer on by `GENS_PER_PASS` and adds the same amount to a generation counter.

Port conflicts are resolved by fixed priority. The engine always wins. On the read port, the display comes next. The loader only contends for the write port. The memory is a behavioural array. The defaults are kept small (16 rows of 16 bits, 3 generations per pass) and both dimensions are parameters.

Top module: `life_row_store`

## Requirements
- R1: A compute read of logical row L returns, on `cmp_rd_data` in the cycle after the request, the last data written to L under the current base.
- R2: When a read and a write hit the same physical row in one cycle, the read returns the data held before that write.
- R3: A compute read and a compute write can be issued in every cycle of a pass with no stall. Each write is visible to later reads.
- R4: A loader write is stored when no compute write is active in that cycle. When a compute write is active, `init_stall` is 1 in that cycle and the loader data is not stored.
- R5: A display request made while no compute read is active has `vid_stall` at 0. It produces `vid_valid`=1 and the row's data on `vid_data` in the next cycle. Without a granted request, `vid_valid` stays 0.
- R6: A display request made during a compute read is handled in one of two ways. If a compute write to the same row is active in that cycle, the request is served with the data being written. Otherwise `vid_stall` is 1 and no `vid_valid` follows.
- R7: The physical row is (logical row + base) mod `ROWS` for every client. A `pass_done` pulse advances `base_row` by `GENS_PER_PASS` mod `ROWS` in the next cycle, and `base_row` holds its value otherwise.
- R8: Each `pass_done` pulse adds `GENS_PER_PASS` to `gen_count`.
- R9: After reset, `base_row` and `gen_count` are 0 and `vid_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_rd_en | input | 1 | Engine row read request |
| cmp_rd_row | input | $clog2(ROWS) | Engine logical read row |
| cmp_rd_data | output | ROW_BITS | Engine read data, one cycle after request |
| cmp_wr_en | input | 1 | Engine row write |
| cmp_wr_row | input | $clog2(ROWS) | Engine logical write row |
| cmp_wr_data | input | ROW_BITS | Engine write data |
| pass_done | input | 1 | Pulse at the end of a pass |
| vid_req | input | 1 | Display row fetch request |
| vid_row | input | $clog2(ROWS) | Display logical row |
| vid_stall | output | 1 | Display request refused this cycle |
| vid_valid | output | 1 | Display data valid |
| vid_data | output | ROW_BITS | Display row data |
| init_wr_en | input | 1 | Loader write request |
| init_row | input | $clog2(ROWS) | Loader logical row |
| init_data | input | ROW_BITS | Loader write data |
| init_stall | output | 1 | Loader write refused this cycle |
| base_row | output | $clog2(ROWS) | Current base pointer |
| gen_count | output | GEN_CNT_W | Completed generations |

## Verification
The bench first loads every row and reads it back through the display path while the engine is idle. This separates address mapping faults from arbitration faults.

A full streaming pass follows. It reads row i while writing row i-1, so it shows whether both ports really run every cycle. Within that pass, a display request that hits the written row is told apart from one that misses. A loader write that collides with an engine write is also included, as is a same-row read/write issued outside the pass that exposes old-data versus new-data behaviour.

Repeated pass pulses then carry the base pointer across its wrap. Reads after each rotation show whether the modulo offset is applied to every client.

// File: rtl/life_row_store_pkg.sv
// Shared types for the grid row store.
package life_row_store_pkg;
    // Source of the display data returned one cycle after a grant.
    typedef enum logic [1:0] {
        VSRC_NONE = 2'd0,
        VSRC_MEM  = 2'd1,
        VSRC_FWD  = 2'd2
    } vid_src_e;
endpackage

// File: rtl/life_row_map.sv
// Maps a logical row to a physical row: (row + base) mod ROWS.
// Assumes row and base are already below ROWS and ROWS >= 2.
module life_row_map #(
    parameter int ROWS = 16,
    parameter int AW   = $clog2(ROWS)
) (
    input  logic [AW-1:0] row,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] phys
);
    localparam logic [AW:0] ROWS_W = (AW+1)'(ROWS);

    logic [AW:0] sum;

    // Add with one extra bit, then fold back once into range.
    always_comb begin
        sum = {1'b0, row} + {1'b0, base};
        if (sum >= ROWS_W) begin
            phys = AW'(sum - ROWS_W);
        end else begin
            phys = sum[AW-1:0];
        end
    end
endmodule

// File: rtl/life_row_mem.sv
// Behavioural 1-read 1-write row memory with a registered read.
// A read and a write to the same word in one cycle return the old word.
// Contents are not reset; only the read register is.
module life_row_mem #(
    parameter int ROW_BITS = 16,
    parameter int ROWS     = 16,
    parameter int AW       = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [ROW_BITS-1:0] wdata,
    input  logic                re,
    input  logic [AW-1:0]       raddr,
    output logic [ROW_BITS-1:0] rdata
);
    logic [ROW_BITS-1:0] mem [ROWS];

    // Write port: store one row.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read port: capture the row as it was before this edge's write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/life_row_arb.sv
// Port arbiter. The read port goes to the engine first, then the display.
// The write port goes to the engine first, then the loader.
// A display request that loses the read port is served by forwarding
// when the engine writes the same physical row that cycle; otherwise
// it is stalled. Assumes the physical addresses come pre-mapped.
module life_row_arb
    import life_row_store_pkg::*;
#(
    parameter int ROW_BITS = 16,
    parameter int ROWS     = 16,
    parameter int AW       = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmp_rd_en,
    input  logic [AW-1:0]       cmp_rd_phys,
    input  logic                cmp_wr_en,
    input  logic [AW-1:0]       cmp_wr_phys,
    input  logic [ROW_BITS-1:0] cmp_wr_data,
    input  logic                vid_req,
    input  logic [AW-1:0]       vid_phys,
    input  logic                init_wr_en,
    input  logic [AW-1:0]       init_phys,
    input  logic [ROW_BITS-1:0] init_data,
    output logic                re,
    output logic [AW-1:0]       raddr,
    output logic                we,
    output logic [AW-1:0]       waddr,
    output logic [ROW_BITS-1:0] wdata,
    output logic                vid_stall,
    output logic                init_stall,
    output vid_src_e            vsrc_q,
    output logic [ROW_BITS-1:0] fwd_q
);
    logic     fwd_hit;
    vid_src_e vsrc_d;

    // Read port grant and display outcome for this cycle.
    always_comb begin
        fwd_hit = cmp_wr_en && (cmp_wr_phys == vid_phys);
        re      = cmp_rd_en || vid_req;
        raddr   = cmp_rd_en ? cmp_rd_phys : vid_phys;
        vsrc_d  = VSRC_NONE;
        vid_stall = 1'b0;
        if (vid_req) begin
            if (!cmp_rd_en) begin
                vsrc_d = VSRC_MEM;
            end else if (fwd_hit) begin
                vsrc_d = VSRC_FWD;
            end else begin
                vid_stall = 1'b1;
            end
        end
    end

    // Write port grant: the engine pre-empts the loader.
    always_comb begin
        we         = cmp_wr_en || init_wr_en;
        waddr      = cmp_wr_en ? cmp_wr_phys : init_phys;
        wdata      = cmp_wr_en ? cmp_wr_data : init_data;
        init_stall = init_wr_en && cmp_wr_en;
    end

    // Remember where the display data will come from next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsrc_q <= VSRC_NONE;
            fwd_q  <= '0;
        end else begin
            vsrc_q <= vsrc_d;
            if (vsrc_d == VSRC_FWD) begin
                fwd_q <= cmp_wr_data;
            end
        end
    end

    // R6: a stall is only raised when the engine holds the read port.
    p_stall_needs_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vid_stall |-> (vid_req && cmp_rd_en));

    // R5: a granted display request yields a return next cycle.
    p_grant_returns_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_req && !vid_stall) |=> (vsrc_q != VSRC_NONE));

    // R5: no return without a request in the previous cycle.
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_req |=> (vsrc_q == VSRC_NONE));

    // R4: a refused loader write never owns the write address.
    p_loader_yields_r4: assert property (@(posedge clk) disable iff (!rst_n)
        init_stall |-> (we && waddr == cmp_wr_phys));
endmodule

// File: rtl/life_row_base.sv
// Base pointer and generation counter. Each pass_done pulse moves the
// base by GENS_PER_PASS rows modulo ROWS and adds GENS_PER_PASS to the
// counter. Assumes GENS_PER_PASS is below ROWS.
module life_row_base #(
    parameter int ROWS          = 16,
    parameter int GENS_PER_PASS = 3,
    parameter int GEN_CNT_W     = 32,
    parameter int AW            = $clog2(ROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pass_done,
    output logic [AW-1:0]        base_row,
    output logic [GEN_CNT_W-1:0] gen_count
);
    localparam logic [AW:0]        STEP   = (AW+1)'(GENS_PER_PASS);
    localparam logic [AW:0]        ROWS_W = (AW+1)'(ROWS);
    localparam logic [GEN_CNT_W-1:0] GSTEP = GEN_CNT_W'(GENS_PER_PASS);

    logic [AW:0] nxt;

    // Next base, folded into range.
    always_comb begin
        nxt = {1'b0, base_row} + STEP;
        if (nxt >= ROWS_W) begin
            nxt = nxt - ROWS_W;
        end
    end

    // Advance pointer and counter at the end of a pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_row  <= '0;
            gen_count <= '0;
        end else if (pass_done) begin
            base_row  <= nxt[AW-1:0];
            gen_count <= gen_count + GSTEP;
        end
    end

    // R7: the base moves by one step modulo ROWS per pass.
    p_base_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> (32'(base_row) == (32'($past(base_row)) + GENS_PER_PASS) % ROWS));

    // R7: the base holds between passes.
    p_base_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !pass_done) |=> $stable(base_row));

    // R7: the base stays inside the row range.
    p_base_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(base_row) < ROWS);

    // R8: the counter grows by the pass depth.
    p_gen_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> (gen_count == $past(gen_count) + GSTEP));
endmodule

// File: rtl/life_row_store.sv
// Grid row store: maps every client's logical row through the rotating
// base, arbitrates the two memory ports and steers returned data.
// Assumes logical rows are below ROWS and pass_done is low in reset.
module life_row_store
    import life_row_store_pkg::*;
#(
    parameter int ROW_BITS      = 16,
    parameter int ROWS          = 16,
    parameter int GENS_PER_PASS = 3,
    parameter int GEN_CNT_W     = 32,
    parameter int AW            = $clog2(ROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmp_rd_en,
    input  logic [AW-1:0]        cmp_rd_row,
    output logic [ROW_BITS-1:0]  cmp_rd_data,
    input  logic                 cmp_wr_en,
    input  logic [AW-1:0]        cmp_wr_row,
    input  logic [ROW_BITS-1:0]  cmp_wr_data,
    input  logic                 pass_done,
    input  logic                 vid_req,
    input  logic [AW-1:0]        vid_row,
    output logic                 vid_stall,
    output logic                 vid_valid,
    output logic [ROW_BITS-1:0]  vid_data,
    input  logic                 init_wr_en,
    input  logic [AW-1:0]        init_row,
    input  logic [ROW_BITS-1:0]  init_data,
    output logic                 init_stall,
    output logic [AW-1:0]        base_row,
    output logic [GEN_CNT_W-1:0] gen_count
);
    localparam int NCLI = 4;

    logic [AW-1:0]       lrow [NCLI];
    logic [AW-1:0]       prow [NCLI];
    logic                re, we;
    logic [AW-1:0]       raddr, waddr;
    logic [ROW_BITS-1:0] wdata, rdata, fwd_q;
    vid_src_e            vsrc_q;

    // Collect the logical rows of all clients in a fixed order.
    always_comb begin
        lrow[0] = cmp_rd_row;
        lrow[1] = cmp_wr_row;
        lrow[2] = vid_row;
        lrow[3] = init_row;
    end

    // One address mapper per client.
    for (genvar i = 0; i < NCLI; i++) begin : g_map
        life_row_map #(.ROWS(ROWS), .AW(AW)) u_map (
            .row  (lrow[i]),
            .base (base_row),
            .phys (prow[i])
        );
    end

    life_row_base #(
        .ROWS(ROWS), .GENS_PER_PASS(GENS_PER_PASS),
        .GEN_CNT_W(GEN_CNT_W), .AW(AW)
    ) u_base (
        .clk(clk), .rst_n(rst_n), .pass_done(pass_done),
        .base_row(base_row), .gen_count(gen_count)
    );

    life_row_arb #(.ROW_BITS(ROW_BITS), .ROWS(ROWS), .AW(AW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .cmp_rd_en(cmp_rd_en), .cmp_rd_phys(prow[0]),
        .cmp_wr_en(cmp_wr_en), .cmp_wr_phys(prow[1]), .cmp_wr_data(cmp_wr_data),
        .vid_req(vid_req), .vid_phys(prow[2]),
        .init_wr_en(init_wr_en), .init_phys(prow[3]), .init_data(init_data),
        .re(re), .raddr(raddr), .we(we), .waddr(waddr), .wdata(wdata),
        .vid_stall(vid_stall), .init_stall(init_stall),
        .vsrc_q(vsrc_q), .fwd_q(fwd_q)
    );

    life_row_mem #(.ROW_BITS(ROW_BITS), .ROWS(ROWS), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .we(we), .waddr(waddr), .wdata(wdata),
        .re(re), .raddr(raddr), .rdata(rdata)
    );

    // Steer returned data to the engine and the display.
    always_comb begin
        cmp_rd_data = rdata;
        vid_valid   = (vsrc_q != VSRC_NONE);
        vid_data    = (vsrc_q == VSRC_FWD) ? fwd_q : rdata;
    end

    // R6: forwarded display data equals the engine row written last cycle.
    p_fwd_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_req && cmp_rd_en && !vid_stall) |=> (vid_data == $past(cmp_wr_data)));

    // R4: the loader is never refused while the engine is not writing.
    p_loader_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_wr_en |-> !init_stall);
endmodule

// File: tb/life_row_store_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected reads into queues, the
// monitor pops and compares them as results appear.
module life_row_store_bench;
    localparam int W  = 16;
    localparam int H  = 16;
    localparam int G  = 3;
    localparam int CW = 32;
    localparam int AW = $clog2(H);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_rd_en = 0, cmp_wr_en = 0, pass_done = 0, vid_req = 0, init_wr_en = 0;
    logic [AW-1:0] cmp_rd_row = '0, cmp_wr_row = '0, vid_row = '0, init_row = '0;
    logic [W-1:0]  cmp_wr_data = '0, init_data = '0;
    logic [W-1:0]  cmp_rd_data, vid_data;
    logic          vid_stall, vid_valid, init_stall;
    logic [AW-1:0] base_row;
    logic [CW-1:0] gen_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0] mdl [H];
    int           m_base = 0;
    int           m_gen  = 0;

    logic [W-1:0] exp_cmp[$];
    string        tag_cmp[$];
    logic [W-1:0] exp_vid[$];
    string        tag_vid[$];

    always #5 clk = ~clk;

    life_row_store #(.ROW_BITS(W), .ROWS(H), .GENS_PER_PASS(G), .GEN_CNT_W(CW)) u_life_row_store (
        .clk(clk), .rst_n(rst_n),
        .cmp_rd_en(cmp_rd_en), .cmp_rd_row(cmp_rd_row), .cmp_rd_data(cmp_rd_data),
        .cmp_wr_en(cmp_wr_en), .cmp_wr_row(cmp_wr_row), .cmp_wr_data(cmp_wr_data),
        .pass_done(pass_done),
        .vid_req(vid_req), .vid_row(vid_row), .vid_stall(vid_stall),
        .vid_valid(vid_valid), .vid_data(vid_data),
        .init_wr_en(init_wr_en), .init_row(init_row), .init_data(init_data),
        .init_stall(init_stall), .base_row(base_row), .gen_count(gen_count)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int ph(input int r);
        return (r + m_base) % H;
    endfunction

    // Monitor: after each edge compare engine and display returns.
    always begin
        bit cr;
        @(posedge clk);
        cr = cmp_rd_en && rst_n;
        #1;
        if (cr) begin
            if (exp_cmp.size() == 0) begin
                check(0, "R1 (no engine expectation)", cmp_rd_data, 0);
            end else begin
                logic [W-1:0] e;
                string t;
                e = exp_cmp.pop_front();
                t = tag_cmp.pop_front();
                check(cmp_rd_data == e, t, cmp_rd_data, e);
            end
        end
        if (vid_valid) begin
            if (exp_vid.size() == 0) begin
                check(0, "R5 (unexpected vid_valid)", 1, 0);
            end else begin
                logic [W-1:0] e;
                string t;
                e = exp_vid.pop_front();
                t = tag_vid.pop_front();
                check(vid_data == e, t, vid_data, e);
            end
        end
    end

    // Driver: apply one cycle of stimulus, predict results, check state.
    task automatic step(input bit crd, input int cr, input bit cwr, input int cw,
                        input logic [W-1:0] cd, input bit vr, input int vrw,
                        input bit iw, input int ir, input logic [W-1:0] id,
                        input bit pd, input string tag);
        bit exp_vst, exp_ist;
        @(negedge clk);
        cmp_rd_en = crd; cmp_rd_row = AW'(cr);
        cmp_wr_en = cwr; cmp_wr_row = AW'(cw); cmp_wr_data = cd;
        vid_req = vr; vid_row = AW'(vrw);
        init_wr_en = iw; init_row = AW'(ir); init_data = id;
        pass_done = pd;
        #1;
        if (crd) begin
            exp_cmp.push_back(mdl[ph(cr)]);
            tag_cmp.push_back(tag);
        end
        exp_vst = 0;
        if (vr) begin
            if (!crd) begin
                exp_vid.push_back(mdl[ph(vrw)]);
                tag_vid.push_back(tag);
            end else if (cwr && ph(cw) == ph(vrw)) begin
                exp_vid.push_back(cd);
                tag_vid.push_back({tag, " R6 forward"});
            end else begin
                exp_vst = 1;
            end
        end
        check(vid_stall == exp_vst, {tag, " R6 vid_stall"}, vid_stall, exp_vst);
        exp_ist = iw && cwr;
        if (iw) check(init_stall == exp_ist, {tag, " R4 init_stall"}, init_stall, exp_ist);
        if (cwr) mdl[ph(cw)] = cd;
        else if (iw) mdl[ph(ir)] = id;
        if (pd) begin
            m_base = (m_base + G) % H;
            m_gen  = m_gen + G;
        end
        @(posedge clk);
        #2;
        if (pd) begin
            check(int'(base_row) == m_base, "R7 base_row", base_row, m_base);
            check(int'(gen_count) == m_gen, "R8 gen_count", gen_count, m_gen);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0,0,0,0,'0,0,0,0,0,'0,0,"idle");
    endtask

    function automatic logic [W-1:0] pat(input int k, input int s);
        return W'((k * 16'h1357) ^ (s * 16'h2a4d) ^ 16'h5a0f);
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state.
        check(base_row == '0, "R9 base_row", base_row, 0);
        check(gen_count == '0, "R9 gen_count", gen_count, 0);
        check(vid_valid == 1'b0, "R9 vid_valid", vid_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: load every row; R5: read every row back through the display.
        for (int r = 0; r < H; r++) step(0,0,0,0,'0,0,0,1,r,pat(r,1),0,"R4 load");
        for (int r = 0; r < H; r++) step(0,0,0,0,'0,1,r,0,0,'0,0,"R5 display");

        // R2: read and write the same row in one cycle returns old data.
        step(1,3,1,3,pat(3,2),0,0,0,0,'0,0,"R2 old data");
        step(1,3,0,0,'0,0,0,0,0,'0,0,"R2 new data visible");

        // R1/R3: streaming pass, read row i while writing row i-1.
        for (int i = 0; i <= H; i++) begin
            bit rd, wr, vr, iw;
            int vrw;
            rd = (i < H);
            wr = (i >= 1);
            vr = (i == 5) || (i == 8);
            vrw = (i == 5) ? 4 : 2;
            iw = (i == 10);
            step(rd, rd ? i : 0, wr, wr ? i-1 : 0, pat(i-1,3), vr, vrw,
                 iw, 0, pat(0,9), (i == H), "R3 stream R1");
        end

        // R4: confirm the refused loader write left row 0 alone.
        step(0,0,0,0,'0,1,(H-G)%H,0,0,'0,0,"R4 refused write left row");

        // R7: after rotation the display sees rotated rows.
        for (int r = 0; r < H; r++) step(0,0,0,0,'0,1,r,0,0,'0,0,"R7 rotated display");

        // R7/R8: more passes carry the base through its wrap.
        for (int p = 0; p < 6; p++) step(0,0,0,0,'0,0,0,0,0,'0,1,"R7 wrap");
        step(0,0,0,0,'0,0,0,1,5,pat(5,7),0,"R7 loader mapped");
        step(1,5,0,0,'0,1,5,0,0,'0,0,"R7 engine mapped");
        step(0,0,0,0,'0,1,5,0,0,'0,0,"R7 display mapped");
        for (int r = 0; r < H; r++) step(0,0,0,0,'0,1,r,0,0,'0,0,"R7 wrapped display");

        idle(4);
        check(exp_cmp.size() == 0, "R1 engine returns outstanding", exp_cmp.size(), 0);
        check(exp_vid.size() == 0, "R5 display returns outstanding", exp_vid.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule